// File: doc/BRIEF.md
# Priority Channel Arbiter with Ring Store

This block takes word streams from N video channels. Channel 0 is the foreground channel: its words go straight to the display output and never touch the shared store. The background channels compete for the single write port of a circular store that stands in for external memory. Each background channel has a 2-bit priority. A winner keeps its grant for a burst of up to BURST words. Words in the store carry their channel number and a 16-bit write timestamp.

A display-select input picks the channel shown. When it selects channel 0, the display follows the foreground input. When it selects a background channel, the oldest live word tagged with that channel is shown and consumed, one per cycle. An empty flag is raised when no such word remains. The store keeps itself in bounds in two ways. A write into a full store discards the oldest slot. The head entry is dropped once it is older than MAX_AGE cycles.

The arbiter is a two-state machine. ARB_IDLE takes the GRANT transition to ARB_BURST when any background channel requests; otherwise it takes IDLE_WAIT and stays. ARB_BURST takes BURST_DONE back to ARB_IDLE on the last word of a burst, and SOURCE_STALL back to ARB_IDLE when the granted channel's valid is low. Otherwise it takes KEEP and stays. Every grant is therefore followed by at least one idle cycle before the next grant. DEPTH must be a power of two, BURST at least 2, and MAX_AGE below 32768.

Top module: `prio_ring_arbiter`

## Requirements
- R1: With disp_sel equal to 0, disp_valid and disp_data follow ch_valid[0] and channel 0's data word in the same cycle, disp_empty is 0, and ch_ready[0] is always 1.
- R2: From ARB_IDLE, the next grant goes to a requesting background channel whose priority field (ch_prio bits [2b+1:2b] for channel b+1) has the largest value among all requesters; 3 is the highest and 0 the lowest.
- R3: A granted channel sees ch_ready high from the cycle after the grant decision. Every cycle with its valid high writes one word. The grant ends after BURST written words, or in the first granted cycle with valid low (no write that cycle). One idle cycle then follows.
- R4: Among requesters tied at the top level, the search starts after the channel last granted at that level, in ascending channel order with wrap-around. Only the level that granted updates its position.
- R5: At most one background ch_ready bit is high in any cycle.
- R6: A write into a store holding DEPTH slots discards the oldest slot in the same cycle, so the newest DEPTH words are kept.
- R7: A stored word whose age (current cycle minus write cycle) exceeds MAX_AGE is never shown, and the head slot is removed once it is expired or already consumed.
- R8: With disp_sel selecting channel c>0, disp_valid is high whenever a live word tagged c exists. disp_data is the oldest such word, and it is consumed at the clock edge, so each word is shown once and in arrival order.
- R9: With disp_sel>0 and no live word tagged with it, disp_empty is 1 and disp_valid is 0.
- R10: After reset no background channel is granted and the store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_valid | input | N_CH | Word-valid per channel |
| ch_data | input | N_CH*DW | Data words, channel c at bits [c*DW +: DW] |
| ch_prio | input | (N_CH-1)*PRIO_W | Priority per background channel, channel b+1 at [b*PRIO_W +: PRIO_W] |
| disp_sel | input | clog2(N_CH) | Channel shown on the display |
| ch_ready | output | N_CH | Word accepted when ready and valid; bit 0 is constant 1 |
| disp_valid | output | 1 | Display word valid |
| disp_data | output | DW | Display word |
| disp_empty | output | 1 | Selected background channel has no live stored word |

## Verification
The assertions check properties that hold on every cycle. They check that at most one background channel is ready, that a burst never exceeds BURST words, and that a burst is held while words keep flowing and dropped after a stall. They also check that a new grant goes to a channel that was requesting, and that the empty flag and display valid are never high together. The choices themselves can only be shown by the bench's reference model across its scenarios: which channel wins a priority contest or a round-robin tie, which words survive overwrite and expiry, and the order in which stored words come back.

// File: rtl/pcar_pkg.sv
package pcar_pkg;

    localparam int TS_W = 16;

    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_BURST = 1'b1
    } arb_state_t;

endpackage

// File: rtl/prio_grant_fsm.sv
module prio_grant_fsm
    import pcar_pkg::*;
#(
    parameter int NB     = 3,
    parameter int PRIO_W = 2,
    parameter int BURST  = 8,
    localparam int BIW   = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NB-1:0]        req,
    input  logic [NB*PRIO_W-1:0] prio,
    output logic                 busy,
    output logic [BIW-1:0]       gnt,
    output logic                 wr_en
);

    localparam int LVLS = 1 << PRIO_W;
    localparam int BTW  = $clog2(BURST);

    arb_state_t        state_q, state_d;
    logic [BIW-1:0]    gnt_q;
    logic [BTW-1:0]    beat_q;
    logic [BIW-1:0]    rr_q [LVLS];

    logic [PRIO_W-1:0] top_lvl;
    logic              any_req;
    logic              found;
    logic [BIW-1:0]    win;

    // winner search: highest level first, then rotate after last grant
    always_comb begin
        int c;
        top_lvl = '0;
        any_req = 1'b0;
        for (int b = 0; b < NB; b++) begin
            if (req[b] && (!any_req || prio[b*PRIO_W +: PRIO_W] > top_lvl)) begin
                top_lvl = prio[b*PRIO_W +: PRIO_W];
                any_req = 1'b1;
            end
        end
        found = 1'b0;
        win   = '0;
        for (int k = 1; k <= NB; k++) begin
            c = int'(rr_q[top_lvl]) + k;
            if (c >= NB) c = c - NB;
            if (!found && req[c] && prio[c*PRIO_W +: PRIO_W] == top_lvl) begin
                found = 1'b1;
                win   = BIW'(c);
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (found) state_d = ARB_BURST;              // GRANT
            end
            ARB_BURST: begin
                if (!req[gnt_q])                    state_d = ARB_IDLE; // SOURCE_STALL
                else if (beat_q == BTW'(BURST - 1)) state_d = ARB_IDLE; // BURST_DONE
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // grant, beat counter and per-level rotation pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q  <= '0;
            beat_q <= '0;
            for (int l = 0; l < LVLS; l++) rr_q[l] <= '0;
        end else if (state_q == ARB_IDLE && found) begin
            gnt_q         <= win;
            beat_q        <= '0;
            rr_q[top_lvl] <= win;
        end else if (state_q == ARB_BURST && req[gnt_q]) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy  = (state_q == ARB_BURST);
        gnt   = gnt_q;
        wr_en = busy && req[gnt_q];
    end

endmodule

// File: rtl/ring_age_store.sv
module ring_age_store
    import pcar_pkg::*;
#(
    parameter int TAG_W   = 2,
    parameter int DW      = 8,
    parameter int DEPTH   = 64,
    parameter int MAX_AGE = 200,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [DW-1:0]    wr_data,
    input  logic [TAG_W-1:0] rd_sel,
    output logic             rd_hit,
    output logic [DW-1:0]    rd_data
);

    logic [DEPTH-1:0] v_q;
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [TS_W-1:0]  ts_q  [DEPTH];
    logic [DW-1:0]    dat_q [DEPTH];
    logic [AW-1:0]    head_q, tail_q;
    logic [CW-1:0]    cnt_q;
    logic [TS_W-1:0]  now_q;

    logic [DEPTH-1:0] fresh;
    logic [DEPTH-1:0] match;
    logic             found;
    logic [AW-1:0]    hit_idx;
    logic             drop;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [TS_W-1:0] age;
        assign age      = now_q - ts_q[g];
        assign fresh[g] = (age <= TS_W'(MAX_AGE));
        assign match[g] = v_q[g] && fresh[g] && (tag_q[g] == rd_sel);
    end

    // oldest matching slot, scanning from head in ring order
    always_comb begin
        logic [AW-1:0] idx;
        found   = 1'b0;
        hit_idx = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_q + AW'(k);
            if (!found && match[idx]) begin
                found   = 1'b1;
                hit_idx = idx;
            end
        end
    end

    assign rd_hit  = found && (rd_sel != '0);
    assign rd_data = dat_q[hit_idx];

    assign drop = (cnt_q != '0) &&
                  (!v_q[head_q] || !fresh[head_q] || (wr_en && cnt_q == CW'(DEPTH)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= '0;
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            now_q  <= '0;
        end else begin
            now_q <= now_q + 1'b1;
            if (rd_hit) v_q[hit_idx] <= 1'b0;
            if (drop) begin
                v_q[head_q] <= 1'b0;
                head_q      <= head_q + 1'b1;
            end
            if (wr_en) begin
                v_q[tail_q] <= 1'b1;
                tail_q      <= tail_q + 1'b1;
            end
            cnt_q <= cnt_q + CW'(wr_en) - CW'(drop);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[tail_q] <= wr_tag;
            ts_q[tail_q]  <= now_q;
            dat_q[tail_q] <= wr_data;
        end
    end

endmodule

// File: rtl/prio_ring_arbiter.sv
module prio_ring_arbiter
    import pcar_pkg::*;
#(
    parameter int N_CH    = 4,
    parameter int DW      = 8,
    parameter int PRIO_W  = 2,
    parameter int DEPTH   = 64,
    parameter int BURST   = 8,
    parameter int MAX_AGE = 200,
    localparam int CHW    = $clog2(N_CH),
    localparam int NB     = N_CH - 1,
    localparam int BIW    = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_CH-1:0]      ch_valid,
    input  logic [N_CH*DW-1:0]   ch_data,
    input  logic [NB*PRIO_W-1:0] ch_prio,
    input  logic [CHW-1:0]       disp_sel,
    output logic [N_CH-1:0]      ch_ready,
    output logic                 disp_valid,
    output logic [DW-1:0]        disp_data,
    output logic                 disp_empty
);

    logic           busy;
    logic [BIW-1:0] gnt;
    logic           wr_en;
    logic [CHW-1:0] wr_tag;
    logic [DW-1:0]  wr_data;
    logic           rd_hit;
    logic [DW-1:0]  rd_data;

    prio_grant_fsm #(
        .NB     (NB),
        .PRIO_W (PRIO_W),
        .BURST  (BURST)
    ) arb_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (ch_valid[N_CH-1:1]),
        .prio  (ch_prio),
        .busy  (busy),
        .gnt   (gnt),
        .wr_en (wr_en)
    );

    assign wr_tag  = CHW'(int'(gnt) + 1);
    assign wr_data = ch_data[(int'(gnt) + 1)*DW +: DW];

    ring_age_store #(
        .TAG_W   (CHW),
        .DW      (DW),
        .DEPTH   (DEPTH),
        .MAX_AGE (MAX_AGE)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_tag  (wr_tag),
        .wr_data (wr_data),
        .rd_sel  (disp_sel),
        .rd_hit  (rd_hit),
        .rd_data (rd_data)
    );

    assign ch_ready[0] = 1'b1;
    for (genvar g = 1; g < N_CH; g++) begin : g_ready
        assign ch_ready[g] = busy && (gnt == BIW'(g - 1));
    end

    always_comb begin
        if (disp_sel == '0) begin
            disp_valid = ch_valid[0];
            disp_data  = ch_data[DW-1:0];
            disp_empty = 1'b0;
        end else begin
            disp_valid = rd_hit;
            disp_data  = rd_data;
            disp_empty = !rd_hit;
        end
    end

endmodule

// File: rtl/prio_ring_arbiter_chk.sv
module prio_ring_arbiter_chk #(
    parameter int NB    = 3,
    parameter int BURST = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NB-1:0] vld_bg,
    input logic [NB-1:0] rdy_bg,
    input logic          disp_valid,
    input logic          disp_empty
);

    localparam int CW = $clog2(BURST + 1) + 1;

    logic [CW-1:0] beats_q;
    logic          take;

    assign take = (rdy_bg & vld_bg) != '0;

    always_ff @(posedge clk) begin
        if (!rst_n || rdy_bg == '0) beats_q <= '0;
        else if (take)              beats_q <= beats_q + 1'b1;
    end

    p_one_writer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rdy_bg));

    p_burst_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        beats_q <= CW'(BURST));

    p_burst_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && beats_q < CW'(BURST - 1)) |=> $stable(rdy_bg));

    p_stall_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_bg != '0 && !take) |=> (rdy_bg == '0));

    p_grant_requested_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_bg != '0 && $past(rdy_bg) == '0) |-> (($past(vld_bg) & rdy_bg) != '0));

    p_empty_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        disp_empty |-> !disp_valid);

endmodule

bind prio_ring_arbiter prio_ring_arbiter_chk #(
    .NB    (N_CH - 1),
    .BURST (BURST)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .vld_bg     (ch_valid[N_CH-1:1]),
    .rdy_bg     (ch_ready[N_CH-1:1]),
    .disp_valid (disp_valid),
    .disp_empty (disp_empty)
);

// File: tb/prio_ring_arbiter_tb_top.sv
module prio_ring_arbiter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_CH  = 4;
    localparam int NB    = 3;
    localparam int DW    = 8;
    localparam int DEPTH = 64;
    localparam int BURST = 8;
    localparam int M_AGE = 200;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_CH-1:0]   ch_valid = '0;
    logic [N_CH*DW-1:0] ch_data = '0;
    logic [NB*2-1:0]   ch_prio = '0;
    logic [1:0]        disp_sel = '0;
    logic [N_CH-1:0]   ch_ready;
    logic              disp_valid;
    logic [DW-1:0]     disp_data;
    logic              disp_empty;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_ring_arbiter #(
        .N_CH(N_CH), .DW(DW), .PRIO_W(2), .DEPTH(DEPTH), .BURST(BURST), .MAX_AGE(M_AGE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_data(ch_data),
        .ch_prio(ch_prio), .disp_sel(disp_sel), .ch_ready(ch_ready),
        .disp_valid(disp_valid), .disp_data(disp_data), .disp_empty(disp_empty)
    );

    typedef struct {
        bit v;
        int tag;
        int ts;
        int data;
    } ent_t;

    ent_t q[$];
    int   m_busy, m_gnt, m_beat, now;
    int   m_rr[4];
    int   errors = 0;
    int   checks = 0;
    bit   done = 0;
    int   seq = 0;

    function automatic int age_of(int ts);
        return (now - ts) & 16'hFFFF;
    endfunction

    function automatic int prio_of(int b);
        return int'(ch_prio[b*2 +: 2]);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // compare outputs against the model, then advance the model one edge
    task automatic compare_and_step();
        int hit;
        int er;
        int wr, wtag, wdat, drop;
        hit = -1;
        if (disp_sel != 0) begin
            foreach (q[j]) begin
                if (hit < 0 && q[j].v && age_of(q[j].ts) <= M_AGE && q[j].tag == int'(disp_sel))
                    hit = j;
            end
        end
        er = 1;
        for (int b = 0; b < NB; b++) if (m_busy != 0 && m_gnt == b) er |= (1 << (b + 1));
        check("R2 R3 R4 R5 R10 ready", int'(ch_ready), er);
        if (disp_sel == 0) begin
            check("R1 disp_valid", int'(disp_valid), int'(ch_valid[0]));
            if (ch_valid[0]) check("R1 disp_data", int'(disp_data), int'(ch_data[DW-1:0]));
            check("R1 disp_empty", int'(disp_empty), 0);
        end else begin
            check("R6 R7 R8 disp_valid", int'(disp_valid), (hit >= 0) ? 1 : 0);
            if (hit >= 0) check("R6 R7 R8 disp_data", int'(disp_data), q[hit].data);
            check("R9 R10 disp_empty", int'(disp_empty), (hit < 0) ? 1 : 0);
        end
        // store update
        wr   = (m_busy != 0 && ch_valid[m_gnt + 1]) ? 1 : 0;
        wtag = m_gnt + 1;
        wdat = int'(ch_data[(m_gnt + 1)*DW +: DW]);
        drop = 0;
        if (q.size() > 0)
            if (!q[0].v || age_of(q[0].ts) > M_AGE || (wr != 0 && q.size() == DEPTH)) drop = 1;
        if (hit >= 0) q[hit].v = 0;
        if (drop != 0) void'(q.pop_front());
        if (wr != 0) q.push_back('{v: 1, tag: wtag, ts: now, data: wdat});
        now = (now + 1) & 16'hFFFF;
        // arbiter update
        if (m_busy == 0) begin
            int lvl, any, c;
            lvl = 0; any = 0;
            for (int b = 0; b < NB; b++)
                if (ch_valid[b + 1] && (any == 0 || prio_of(b) > lvl)) begin lvl = prio_of(b); any = 1; end
            if (any != 0) begin
                for (int k = 1; k <= NB; k++) begin
                    c = (m_rr[lvl] + k) % NB;
                    if (m_busy == 0 && ch_valid[c + 1] && prio_of(c) == lvl) begin
                        m_busy = 1; m_gnt = c; m_beat = 0; m_rr[lvl] = c;
                    end
                end
            end
        end else if (!ch_valid[m_gnt + 1]) begin
            m_busy = 0;
        end else if (m_beat == BURST - 1) begin
            m_busy = 0;
        end else begin
            m_beat++;
        end
    endtask

    task automatic drive(input logic [3:0] vld, input logic [1:0] sel);
        ch_valid = vld;
        disp_sel = sel;
        for (int c = 0; c < N_CH; c++) ch_data[c*DW +: DW] = DW'((c << 6) | (seq & 63));
        seq++;
    endtask

    task automatic cycle();
        #1;
        compare_and_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_busy = 0; m_gnt = 0; m_beat = 0; now = 0;
        for (int l = 0; l < 4; l++) m_rr[l] = 0;
        @(negedge clk);
        // R10: reset state seen during reset
        drive(4'b1110, 2'd1);
        repeat (3) begin
            #1;
            check("R10 no grant in reset", int'(ch_ready), 1);
            check("R10 empty in reset", int'(disp_empty), 1);
            @(negedge clk);
        end
        rst_n = 1'b1;
        // R1 and R4: tied priorities, foreground shown
        ch_prio = 6'b01_01_01;
        for (int i = 0; i < 40; i++) begin drive({3'b111, 1'(i % 3 != 0)}, 2'd0); cycle(); end
        // R2: distinct priorities, irregular requests
        ch_prio = 6'b10_11_00;
        for (int i = 0; i < 80; i++) begin drive(4'($urandom_range(0, 15)), 2'd0); cycle(); end
        // R6: fill past capacity
        ch_prio = 6'b00_00_00;
        for (int i = 0; i < 120; i++) begin drive(4'b1110, 2'd0); cycle(); end
        // R8 and R9: drain each background channel in turn
        for (int s = 1; s < N_CH; s++)
            for (int i = 0; i < 40; i++) begin drive(4'b0000, 2'(s)); cycle(); end
        // R7: refill, let everything age out, then look again
        for (int i = 0; i < 30; i++) begin drive(4'b1110, 2'd0); cycle(); end
        for (int i = 0; i < M_AGE + 80; i++) begin drive(4'b0000, 2'd0); cycle(); end
        for (int s = 1; s < N_CH; s++)
            for (int i = 0; i < 4; i++) begin drive(4'b0000, 2'(s)); cycle(); end
        // mixed traffic with changing selection and priorities
        for (int i = 0; i < 3000; i++) begin
            if (i % 200 == 0) ch_prio = 6'($urandom_range(0, 63));
            drive(4'($urandom_range(0, 15)), (i % 64 < 24) ? 2'd0 : 2'((i / 64) % 3 + 1));
            cycle();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule